// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block keeps the eight-bit status byte of a serial flash target and decides, cycle by cycle, whether each decoded command may take effect. The command decoder in front of it raises one strobe per command: set or clear the write-enable latch, write status, page program, three sizes of erase, read status, enter sleep and wake. The block answers each strobe in the same cycle with an accept or a reject flag. An accepted program, erase or status write sets the busy flag. Busy then holds until the internal operation timer returns a one-cycle completion pulse.

Several rules gate the array-modifying commands. The write-enable latch must be set first. The target address must lie outside the protected region, which the block-protect field and the top/bottom bit define. A status write is also refused while the lock bit is set and the write-protect pin is driven low. In sleep only the wake command is answered, and while busy only the status read is answered.

Top module: `flash_status_ctrl`

## Requirements
- R1: After synchronous reset the status byte reads 0x00 and both `busy` and `sleeping` are low.
- R2: Status layout: bit 0 busy, bit 1 write-enable latch, bits 4..2 block-protect field, bit 5 top/bottom select, bit 6 always 0, bit 7 lock bit. An accepted status write loads only bits 7 and 5..2 from `stat_wdata`, and the values written to bits 6, 1 and 0 are discarded.
- R3: An accepted write-enable strobe sets status bit 1 on the next cycle, and an accepted write-disable strobe clears it.
- R4: Program, sector erase, block erase, chip erase and status write are rejected and change nothing while status bit 1 is 0.
- R5: An accepted program, erase or status write sets status bit 0 on the next cycle. Bit 0 stays 1 until a cycle in which `op_done` is high, and bits 0 and 1 both read 0 after that cycle.
- R6: While busy, only the read-status strobe is accepted. Every other strobe is rejected and has no effect.
- R7: A status write is rejected when bit 7 is 1 and `wp_n` is 0. With `wp_n` at 1, or with bit 7 at 0, the pin does not affect the status write.
- R8: For a block-protect value k from 1 to 7, the protected region holds the 2^(ADDR_W-7+k) highest addresses when bit 5 is 0, and the same number of lowest addresses when bit 5 is 1. Value 0 protects nothing. A program, sector erase or block erase whose `op_addr` falls in the region is rejected and leaves the write-enable latch set. A chip erase is rejected whenever the field is non-zero.
- R9: An accepted sleep strobe sets `sleeping` on the next cycle. While asleep, every strobe except wake is rejected and the status byte does not change. An accepted wake clears `sleeping`, and a wake given while awake is rejected.
- R10: Accept and reject are judged from the state held before the clock edge. A strobe presented in the same cycle as `op_done` is therefore still treated as arriving during busy.
- R11: In a cycle with a strobe, exactly one of `cmd_accept` and `cmd_reject` is high. In a cycle with no strobe, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Write-enable command strobe |
| cmd_wr_dis | input | 1 | Write-disable command strobe |
| cmd_wr_stat | input | 1 | Status-write command strobe |
| stat_wdata | input | 8 | Byte offered with a status write |
| cmd_prog | input | 1 | Page-program command strobe |
| cmd_sec_erase | input | 1 | Sector-erase command strobe |
| cmd_blk_erase | input | 1 | Block-erase command strobe |
| cmd_chip_erase | input | 1 | Chip-erase command strobe |
| op_addr | input | ADDR_W | Target address of program or erase |
| cmd_rd_stat | input | 1 | Read-status command strobe |
| cmd_sleep | input | 1 | Enter-sleep command strobe |
| cmd_wake | input | 1 | Wake command strobe |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Completion pulse from the operation timer |
| status | output | 8 | Status byte |
| busy | output | 1 | Operation in progress |
| sleeping | output | 1 | Sleep state active |
| cmd_accept | output | 1 | Current strobe is accepted |
| cmd_reject | output | 1 | Current strobe is rejected |

## Verification
The collision that matters is a completion pulse from the timer arriving in the same cycle as a new command strobe. The bench raises `op_done` together with a write-enable strobe and expects a reject. It then expects both busy and the latch to read clear on the following cycle, with the latch left clear and not set again. It also sends a read-status strobe while busy and expects an accept. The protected-region sweep runs each top/bottom and field setting over 128 addresses that span the array. For each address the bench computes the expected verdict from region size arithmetic.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;

    localparam int unsigned STAT_W = 8;
    localparam logic [STAT_W-1:0] CFG_WR_MASK = 8'hBC;
    localparam int unsigned BIT_LOCK = 7;
    localparam int unsigned BIT_TB   = 5;
    localparam int unsigned BP_HI    = 4;
    localparam int unsigned BP_LO    = 2;
    localparam int unsigned PROT_STEPS = 7;

    typedef struct packed {
        logic wren;
        logic wrdi;
        logic wrsr;
        logic prog;
        logic serase;
        logic berase;
        logic cerase;
        logic rdsr;
        logic sleep;
        logic wake;
    } strobe_t;

    typedef enum logic [3:0] {
        OP_NONE, OP_WREN, OP_WRDI, OP_WRSR, OP_PROG, OP_SERASE,
        OP_BERASE, OP_CERASE, OP_RDSR, OP_SLEEP, OP_WAKE
    } op_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_SET_WEL, ACT_CLR_WEL, ACT_LOAD_CFG,
        ACT_START, ACT_SLEEP, ACT_WAKE
    } act_e;

    function automatic op_e encode_op(input strobe_t s);
        op_e o;
        o = OP_NONE;
        if      (s.wake)   o = OP_WAKE;
        else if (s.sleep)  o = OP_SLEEP;
        else if (s.rdsr)   o = OP_RDSR;
        else if (s.wrdi)   o = OP_WRDI;
        else if (s.wren)   o = OP_WREN;
        else if (s.wrsr)   o = OP_WRSR;
        else if (s.cerase) o = OP_CERASE;
        else if (s.berase) o = OP_BERASE;
        else if (s.serase) o = OP_SERASE;
        else if (s.prog)   o = OP_PROG;
        return o;
    endfunction

    function automatic logic is_addressed(input op_e o);
        return (o == OP_PROG) || (o == OP_SERASE) || (o == OP_BERASE);
    endfunction

endpackage

// File: rtl/fsr_prot_decode.sv
`timescale 1ns/1ps
module fsr_prot_decode
    import fsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bp,
    input  logic              from_bottom,
    output logic              in_prot
);
    localparam int unsigned CW = ADDR_W + 1;
    localparam logic [CW-1:0] FULL = {1'b1, {ADDR_W{1'b0}}};

    logic [CW-1:0]         addr_x;
    logic [PROT_STEPS:1]   hit_top;
    logic [PROT_STEPS:1]   hit_bot;

    assign addr_x = {1'b0, addr};

    generate
        for (genvar k = 1; k <= PROT_STEPS; k++) begin : g_step
            localparam int unsigned SZ_LOG = ADDR_W - PROT_STEPS + k;
            localparam logic [CW-1:0] SZ = {{ADDR_W{1'b0}}, 1'b1} << SZ_LOG;
            localparam logic [CW-1:0] TOP_LO = FULL - SZ;
            assign hit_top[k] = (addr_x >= TOP_LO);
            assign hit_bot[k] = (addr_x < SZ);
        end
    endgenerate

    always_comb begin
        in_prot = 1'b0;
        for (int k = 1; k <= PROT_STEPS; k++) begin
            if (bp == 3'(k)) begin
                in_prot = from_bottom ? hit_bot[k] : hit_top[k];
            end
        end
    end

endmodule

// File: rtl/fsr_gate.sv
`timescale 1ns/1ps
module fsr_gate
    import fsr_pkg::*;
(
    input  op_e   op,
    input  logic  sleeping,
    input  logic  busy,
    input  logic  wel,
    input  logic  lock,
    input  logic  bp_any,
    input  logic  wp_n,
    input  logic  in_prot,
    output act_e  act,
    output logic  accept,
    output logic  reject
);
    logic ok;
    act_e act_ok;

    always_comb begin
        ok     = 1'b0;
        act_ok = ACT_NONE;
        unique case (op)
            OP_WREN:   begin ok = 1'b1; act_ok = ACT_SET_WEL; end
            OP_WRDI:   begin ok = 1'b1; act_ok = ACT_CLR_WEL; end
            OP_RDSR:   begin ok = 1'b1; end
            OP_SLEEP:  begin ok = 1'b1; act_ok = ACT_SLEEP; end
            OP_WAKE:   begin ok = 1'b0; act_ok = ACT_WAKE; end
            OP_WRSR:   begin ok = wel && !(lock && !wp_n); act_ok = ACT_LOAD_CFG; end
            OP_CERASE: begin ok = wel && !bp_any; act_ok = ACT_START; end
            OP_PROG, OP_SERASE, OP_BERASE:
                       begin ok = wel && !in_prot; act_ok = ACT_START; end
            default:   begin ok = 1'b0; end
        endcase

        if (sleeping) begin
            ok = (op == OP_WAKE);
        end else if (busy) begin
            ok = (op == OP_RDSR);
        end
    end

    assign accept = (op != OP_NONE) && ok;
    assign reject = (op != OP_NONE) && !ok;
    assign act    = accept ? act_ok : ACT_NONE;

endmodule

// File: rtl/fsr_regs.sv
`timescale 1ns/1ps
module fsr_regs
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  logic [STAT_W-1:0] wdata,
    input  logic              op_done,
    output logic [STAT_W-1:0] cfg_q,
    output logic              wel_q,
    output logic              busy_q,
    output logic              sleep_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            wel_q   <= 1'b0;
            busy_q  <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            if (busy_q && op_done) begin
                busy_q <= 1'b0;
                wel_q  <= 1'b0;
            end
            unique case (act)
                ACT_SET_WEL:  wel_q <= 1'b1;
                ACT_CLR_WEL:  wel_q <= 1'b0;
                ACT_LOAD_CFG: begin
                    cfg_q  <= wdata & CFG_WR_MASK;
                    busy_q <= 1'b1;
                end
                ACT_START:    busy_q  <= 1'b1;
                ACT_SLEEP:    sleep_q <= 1'b1;
                ACT_WAKE:     sleep_q <= 1'b0;
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/flash_status_ctrl.sv
`timescale 1ns/1ps
module flash_status_ctrl
    import fsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr_en,
    input  logic              cmd_wr_dis,
    input  logic              cmd_wr_stat,
    input  logic [7:0]        stat_wdata,
    input  logic              cmd_prog,
    input  logic              cmd_sec_erase,
    input  logic              cmd_blk_erase,
    input  logic              cmd_chip_erase,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              cmd_rd_stat,
    input  logic              cmd_sleep,
    input  logic              cmd_wake,
    input  logic              wp_n,
    input  logic              op_done,
    output logic [7:0]        status,
    output logic              busy,
    output logic              sleeping,
    output logic              cmd_accept,
    output logic              cmd_reject
);
    strobe_t           stb;
    op_e               op;
    act_e              act;
    logic [STAT_W-1:0] cfg_q;
    logic              wel_q, busy_q, sleep_q;
    logic              in_prot, gate_prot;

    assign stb = '{wren: cmd_wr_en, wrdi: cmd_wr_dis, wrsr: cmd_wr_stat,
                   prog: cmd_prog, serase: cmd_sec_erase, berase: cmd_blk_erase,
                   cerase: cmd_chip_erase, rdsr: cmd_rd_stat,
                   sleep: cmd_sleep, wake: cmd_wake};
    assign op = encode_op(stb);

    fsr_prot_decode #(.ADDR_W(ADDR_W)) u_prot (
        .addr        (op_addr),
        .bp          (cfg_q[BP_HI:BP_LO]),
        .from_bottom (cfg_q[BIT_TB]),
        .in_prot     (in_prot)
    );

    assign gate_prot = in_prot && is_addressed(op);

    fsr_gate u_gate (
        .op       (op),
        .sleeping (sleep_q),
        .busy     (busy_q),
        .wel      (wel_q),
        .lock     (cfg_q[BIT_LOCK]),
        .bp_any   (|cfg_q[BP_HI:BP_LO]),
        .wp_n     (wp_n),
        .in_prot  (gate_prot),
        .act      (act),
        .accept   (cmd_accept),
        .reject   (cmd_reject)
    );

    fsr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .wdata   (stat_wdata),
        .op_done (op_done),
        .cfg_q   (cfg_q),
        .wel_q   (wel_q),
        .busy_q  (busy_q),
        .sleep_q (sleep_q)
    );

    assign status   = cfg_q | {6'b0, wel_q, busy_q};
    assign busy     = busy_q;
    assign sleeping = sleep_q;

endmodule

// File: rtl/fsr_checker.sv
`timescale 1ns/1ps
module fsr_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr_stat,
    input logic       cmd_prog,
    input logic       cmd_sec_erase,
    input logic       cmd_blk_erase,
    input logic       cmd_chip_erase,
    input logic       cmd_rd_stat,
    input logic       cmd_wake,
    input logic       wp_n,
    input logic       op_done,
    input logic [7:0] status,
    input logic       busy,
    input logic       sleeping,
    input logic       cmd_accept,
    input logic       cmd_reject
);
    logic modify_req;
    assign modify_req = cmd_prog || cmd_sec_erase || cmd_blk_erase || cmd_chip_erase || cmd_wr_stat;

    AST_ACC_REJ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_reject)); // R11
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy && !op_done |=> busy); // R5
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        busy && op_done |=> !status[0] && !status[1]); // R5
    AST_NEED_WEL: assert property (@(posedge clk) disable iff (rst)
        modify_req && !status[1] |-> cmd_reject); // R4
    AST_BUSY_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        busy && cmd_accept |-> cmd_rd_stat); // R6
    AST_LOCKED_STATUS: assert property (@(posedge clk) disable iff (rst)
        cmd_wr_stat && status[7] && !wp_n |-> cmd_reject); // R7
    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        sleeping && !cmd_wake |=> $stable(status)); // R9
endmodule

bind flash_status_ctrl fsr_checker u_fsr_checker (
    .clk            (clk),
    .rst            (rst),
    .cmd_wr_stat    (cmd_wr_stat),
    .cmd_prog       (cmd_prog),
    .cmd_sec_erase  (cmd_sec_erase),
    .cmd_blk_erase  (cmd_blk_erase),
    .cmd_chip_erase (cmd_chip_erase),
    .cmd_rd_stat    (cmd_rd_stat),
    .cmd_wake       (cmd_wake),
    .wp_n           (wp_n),
    .op_done        (op_done),
    .status         (status),
    .busy           (busy),
    .sleeping       (sleeping),
    .cmd_accept     (cmd_accept),
    .cmd_reject     (cmd_reject)
);

// File: tb/tb_flash_status_ctrl.sv
`timescale 1ns/1ps
module tb_flash_status_ctrl;
    localparam int AW = 16;
    localparam int C_NONE = 0, C_WREN = 1, C_WRDI = 2, C_WRSR = 3, C_PROG = 4,
                   C_SERASE = 5, C_BERASE = 6, C_CERASE = 7, C_RDSR = 8,
                   C_SLEEP = 9, C_WAKE = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wr_en = 0, cmd_wr_dis = 0, cmd_wr_stat = 0, cmd_prog = 0;
    logic cmd_sec_erase = 0, cmd_blk_erase = 0, cmd_chip_erase = 0;
    logic cmd_rd_stat = 0, cmd_sleep = 0, cmd_wake = 0;
    logic [7:0] stat_wdata = 0;
    logic [AW-1:0] op_addr = 0;
    logic wp_n = 1, op_done = 0;
    logic [7:0] status;
    logic busy, sleeping, cmd_accept, cmd_reject;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_status_ctrl #(.ADDR_W(AW)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input int c, input logic [7:0] d, input logic [AW-1:0] a,
                        input logic dn, output logic acc);
        @(negedge clk);
        cmd_wr_en = (c == C_WREN);   cmd_wr_dis = (c == C_WRDI);
        cmd_wr_stat = (c == C_WRSR); cmd_prog = (c == C_PROG);
        cmd_sec_erase = (c == C_SERASE); cmd_blk_erase = (c == C_BERASE);
        cmd_chip_erase = (c == C_CERASE); cmd_rd_stat = (c == C_RDSR);
        cmd_sleep = (c == C_SLEEP);  cmd_wake = (c == C_WAKE);
        stat_wdata = d; op_addr = a; op_done = dn;
        #1;
        acc = cmd_accept;
        // R11: one verdict per strobe, none when idle
        check((cmd_accept ^ cmd_reject) == (c != C_NONE), "R11",
              {cmd_accept, cmd_reject}, (c != C_NONE) ? 1 : 0);
        @(negedge clk);
        {cmd_wr_en, cmd_wr_dis, cmd_wr_stat, cmd_prog, cmd_sec_erase, cmd_blk_erase,
         cmd_chip_erase, cmd_rd_stat, cmd_sleep, cmd_wake, op_done} = '0;
    endtask

    task automatic cmd(input int c, input logic [7:0] d, input bit exp_acc, input string req);
        logic acc;
        send(c, d, '0, 1'b0, acc);
        check(acc == exp_acc, req, acc, exp_acc);
    endtask

    task automatic expect_stat(input logic [7:0] e, input string req);
        check(status == e, req, status, e);
    endtask

    task automatic done_pulse();
        logic acc;
        send(C_NONE, 8'h00, '0, 1'b1, acc);
    endtask

    function automatic bit prot_model(input bit tb, input int bp, input int addr);
        int sz;
        if (bp == 0) return 0;
        sz = 1 << (AW - 7 + bp);
        if (tb) return addr < sz;
        return addr >= (1 << AW) - sz;
    endfunction

    initial begin
        logic acc;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(status == 8'h00 && !busy && !sleeping, "R1", {status, busy, sleeping}, 0);

        // R3
        cmd(C_WREN, 0, 1, "R3");  expect_stat(8'h02, "R3");
        cmd(C_WRDI, 0, 1, "R3");  expect_stat(8'h00, "R3");

        // R4
        cmd(C_PROG, 0, 0, "R4");  cmd(C_WRSR, 8'hFF, 0, "R4");
        cmd(C_CERASE, 0, 0, "R4"); expect_stat(8'h00, "R4");

        // R2: discard of bits 6,1,0
        cmd(C_WREN, 0, 1, "R2");
        cmd(C_WRSR, 8'h43, 1, "R2"); expect_stat(8'h03, "R2");
        done_pulse();                expect_stat(8'h00, "R2");

        // R2/R5/R6: write all ones
        cmd(C_WREN, 0, 1, "R5");
        cmd(C_WRSR, 8'hFF, 1, "R5"); expect_stat(8'hBF, "R2");
        cmd(C_WREN, 0, 0, "R6");  cmd(C_WRDI, 0, 0, "R6");
        cmd(C_SLEEP, 0, 0, "R6"); cmd(C_RDSR, 0, 1, "R6");
        expect_stat(8'hBF, "R5");
        // R10: strobe in the completion cycle still sees busy
        send(C_WREN, 0, '0, 1'b1, acc);
        check(acc == 0, "R10", acc, 0);
        expect_stat(8'hBC, "R5");

        // R7
        cmd(C_WREN, 0, 1, "R7");
        wp_n = 0;
        cmd(C_WRSR, 8'h00, 0, "R7"); expect_stat(8'hBE, "R7");
        wp_n = 1;
        cmd(C_WRSR, 8'h80, 1, "R7"); expect_stat(8'h83, "R7");
        done_pulse();
        cmd(C_WREN, 0, 1, "R7");
        cmd(C_WRSR, 8'h00, 1, "R7"); done_pulse();
        cmd(C_WREN, 0, 1, "R7");
        wp_n = 0;
        cmd(C_WRSR, 8'h04, 1, "R7"); expect_stat(8'h07, "R7");
        wp_n = 1;
        done_pulse();

        // R8: chip erase
        cmd(C_WREN, 0, 1, "R8");
        cmd(C_CERASE, 0, 0, "R8");  expect_stat(8'h06, "R8");
        cmd(C_WRSR, 8'h00, 1, "R8"); done_pulse();
        cmd(C_WREN, 0, 1, "R8");
        cmd(C_CERASE, 0, 1, "R8");  expect_stat(8'h03, "R8");
        done_pulse();               expect_stat(8'h00, "R8");

        // R8: sweep
        for (int tb = 0; tb < 2; tb++) begin
            for (int bp = 0; bp < 8; bp++) begin
                cmd(C_WREN, 0, 1, "R8");
                cmd(C_WRSR, 8'(tb << 5 | bp << 2), 1, "R8");
                done_pulse();
                for (int t = 0; t < 128; t++) begin
                    int addr;
                    int c;
                    bit p;
                    addr = (t << (AW - 7)) | ((t * 37) & ((1 << (AW - 7)) - 1));
                    c = (t % 3 == 0) ? C_PROG : ((t % 3 == 1) ? C_SERASE : C_BERASE);
                    p = prot_model(tb[0], bp, addr);
                    cmd(C_WREN, 0, 1, "R8");
                    send(c, 0, AW'(addr), 1'b0, acc);
                    check(acc == !p, "R8", acc, !p);
                    if (p) begin
                        check(status[1:0] == 2'b10, "R8", status, 2);
                        cmd(C_WRDI, 0, 1, "R8");
                    end else begin
                        check(status[1:0] == 2'b11, "R8", status, 3);
                        done_pulse();
                    end
                end
            end
        end
        cmd(C_WREN, 0, 1, "R8"); cmd(C_WRSR, 8'h00, 1, "R8"); done_pulse();
        expect_stat(8'h00, "R8");

        // R9
        cmd(C_WAKE, 0, 0, "R9");
        cmd(C_WREN, 0, 1, "R9");
        cmd(C_SLEEP, 0, 1, "R9");
        check(sleeping == 1, "R9", sleeping, 1);
        cmd(C_WRDI, 0, 0, "R9"); cmd(C_RDSR, 0, 0, "R9");
        cmd(C_WRSR, 8'hFF, 0, "R9"); cmd(C_PROG, 0, 0, "R9");
        expect_stat(8'h02, "R9");
        cmd(C_WAKE, 0, 1, "R9");
        check(sleeping == 0, "R9", sleeping, 0);
        cmd(C_WRDI, 0, 1, "R9"); expect_stat(8'h00, "R9");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule